// File: doc/BRIEF.md
# Mixed-Function Four-Pin GPIO Port

This block is the register side of a four-pin general purpose port in a small microcontroller. It sits on a simple internal register bus with an address, a write strobe, write data and combinational read data. It holds three registers: an output data latch, a direction register and an analog-select register. From these it drives the pad output-enable and output-data lines. It also tells the converter which pins are in analog mode.

The three low pins are bidirectional. Each one can be a digital I/O or an analog input for the converter. In analog mode a pin's digital read path is cut and its driver is turned off. The top pin never drives. When the reset-enable configuration input is high, the top pin becomes an active-low master reset input: its weak pull-up is turned on and a low level raises a reset request.

There are two resets. The power-on reset is asynchronous and active low. It sets the direction and analog registers to all ones and leaves the data latch undefined. The soft reset is synchronous and active low. It sets the same two registers to all ones but keeps the data latch.

Top module: `gpio_mixport`

## Requirements
- R1: While and after power-on reset (`por_n` low), the direction register reads 0x0F, the analog-select register reads 0x07, every `pad_oe` bit is 0 and `ana_sel` is all ones.
- R2: A cycle with `soft_rst_n` low at a rising clock edge sets the direction register to 0x0F and the analog-select register to 0x07. Bus writes in that cycle are dropped.
- R3: A soft reset leaves the data latch unchanged. Its value reappears on `pad_out` once the pins are made digital outputs again.
- R4: Address map: 0 = port data, 1 = direction (bit i = 1 means input), 2 = analog select (bit i = 1 means analog), 3 = unmapped and reads 0. A write with `bus_we` high updates the addressed register at the next rising edge. Register reads return the stored bits in their low positions.
- R5: For pins 0 to 2, `pad_oe[i]` is 1 exactly when direction bit i is 0 and analog bit i is 0. `pad_out[i]` carries data latch bit i.
- R6: `pad_oe[3]` and `pad_out[3]` are always 0, whatever direction bit 3 holds. Direction bit 3 can still be stored and read back.
- R7: A read at address 0 returns `pad_in[i]` in bit i for pins 0 to 2, or 0 for a pin in analog mode. Bit 3 returns `pad_in[3]` while `mclr_cfg` is 0.
- R8: While `mclr_cfg` is 1, `pullup_en` is 1, `reset_req` equals the inverse of `pad_in[3]`, and bit 3 of a port read is 0. While it is 0, both outputs are 0.
- R9: Write-data bits above the implemented width are ignored. The direction register upper bits read 0, and bit 3 of a data write is not stored.
- R10: `ana_sel[i]` mirrors analog-select bit i for pins 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for the addressed register |
| pad_in | input | NPINS (4) | Pin levels from the pads |
| pad_oe | output | NPINS (4) | Pad output enable, 1 drives the pin |
| pad_out | output | NPINS (4) | Pad output data |
| ana_sel | output | NPINS-1 (3) | Analog mode flags for the converter inputs |
| mclr_cfg | input | 1 | Configuration: top pin acts as master reset |
| pullup_en | output | 1 | Weak pull-up enable for the top pin |
| reset_req | output | 1 | Reset request while the top pin is held low |

## Verification
The bench builds the block with its default values: four pins, an 8-bit bus and a 2-bit address. With three analog-capable pins, every direction and analog combination (64 in all) can be swept exhaustively, and every bus address code, including the unmapped one, can be read. Four pins also allow all sixteen pad levels to be crossed with both settings of the reset-enable input. A behavioural model compares the outputs on every clock.

// File: rtl/gpio_mix_pkg.sv
package gpio_mix_pkg;
  // register selector codes on the bus address
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_ANA  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_mix_regs.sv
module gpio_mix_regs
  import gpio_mix_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int ADDR_W = 2,
  localparam int NANA  = NPINS - 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  wr_bits,
  output logic [NANA-1:0]   dat_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NANA-1:0]   ana_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(SEL_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(SEL_DIR);
  localparam logic [ADDR_W-1:0] A_ANA  = ADDR_W'(SEL_ANA);

  // one-hot write decode: {ana, dir, data}
  function automatic logic [2:0] wr_decode(logic [ADDR_W-1:0] a, logic we, logic srst_n);
    logic [2:0] d;
    d = 3'b000;
    if (we && srst_n) begin
      d[0] = (a == A_DATA);
      d[1] = (a == A_DIR);
      d[2] = (a == A_ANA);
    end
    return d;
  endfunction

  logic [2:0] wr_hot;
  logic dat_wr, dir_wr, ana_wr;
  assign wr_hot = wr_decode(bus_addr, bus_we, soft_rst_n);
  assign dat_wr = wr_hot[0];
  assign dir_wr = wr_hot[1];
  assign ana_wr = wr_hot[2];

  // control registers: both reset kinds restore all ones
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q <= '1;
      ana_q <= '1;
    end else if (!soft_rst_n) begin
      dir_q <= '1;
      ana_q <= '1;
    end else begin
      if (dir_wr) dir_q <= wr_bits;
      if (ana_wr) ana_q <= wr_bits[NANA-1:0];
    end
  end

  // data latch: undefined after power-on, kept through soft reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dat_q <= 'x;
    end else if (dat_wr) begin
      dat_q <= wr_bits[NANA-1:0];
    end
  end

  a_r2_soft_restores: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n |=> (dir_q == '1 && ana_q == '1));

  a_r4_ana_write: assert property (@(posedge clk) disable iff (!por_n)
    ana_wr |=> ana_q == $past(wr_bits[NANA-1:0]));
endmodule

// File: rtl/gpio_mix_pin.sv
module gpio_mix_pin (
  input  logic dir_b,
  input  logic ana_b,
  input  logic lat_b,
  input  logic pad_b,
  output logic oe_b,
  output logic out_b,
  output logic rd_b
);
  // driver only for a digital pin configured as output
  function automatic logic drive_on(logic dir_in, logic analog);
    return !dir_in && !analog;
  endfunction

  assign oe_b  = drive_on(dir_b, ana_b);
  assign out_b = lat_b;
  assign rd_b  = ana_b ? 1'b0 : pad_b;
endmodule

// File: rtl/gpio_mix_rstpin.sv
module gpio_mix_rstpin (
  input  logic cfg_rst,
  input  logic pad_b,
  output logic rd_b,
  output logic pull_en,
  output logic req
);
  assign pull_en = cfg_rst;
  assign req     = cfg_rst && !pad_b;
  assign rd_b    = cfg_rst ? 1'b0 : pad_b;
endmodule

// File: rtl/gpio_mixport.sv
module gpio_mixport
  import gpio_mix_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-2:0]  ana_sel,
  input  logic              mclr_cfg,
  output logic              pullup_en,
  output logic              reset_req
);
  localparam int NANA = NPINS - 1;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(SEL_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(SEL_DIR);
  localparam logic [ADDR_W-1:0] A_ANA  = ADDR_W'(SEL_ANA);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-NPINS){1'b0}}, {NPINS{1'b1}}};

  logic [NANA-1:0]  dat_w;
  logic [NPINS-1:0] dir_w;
  logic [NANA-1:0]  ana_w;
  logic [NPINS-1:0] port_rd;

  gpio_mix_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .soft_rst_n (soft_rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .wr_bits    (bus_wdata[NPINS-1:0]),
    .dat_q      (dat_w),
    .dir_q      (dir_w),
    .ana_q      (ana_w)
  );

  for (genvar i = 0; i < NANA; i++) begin : g_pin
    gpio_mix_pin u_pin (
      .dir_b (dir_w[i]),
      .ana_b (ana_w[i]),
      .lat_b (dat_w[i]),
      .pad_b (pad_in[i]),
      .oe_b  (pad_oe[i]),
      .out_b (pad_out[i]),
      .rd_b  (port_rd[i])
    );
  end

  gpio_mix_rstpin u_rstpin (
    .cfg_rst (mclr_cfg),
    .pad_b   (pad_in[NPINS-1]),
    .rd_b    (port_rd[NPINS-1]),
    .pull_en (pullup_en),
    .req     (reset_req)
  );

  // input-only pin: never driven
  assign pad_oe[NPINS-1]  = 1'b0;
  assign pad_out[NPINS-1] = 1'b0;
  assign ana_sel          = ana_w;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_DATA)     bus_rdata[NPINS-1:0] = port_rd;
    else if (bus_addr == A_DIR) bus_rdata[NPINS-1:0] = dir_w;
    else if (bus_addr == A_ANA) bus_rdata[NANA-1:0]  = ana_w;
  end

  a_r5_oe_excludes_analog: assert property (@(posedge clk) disable iff (!por_n)
    (pad_oe[NANA-1:0] & ana_sel) == '0);

  a_r8_req_has_pullup: assert property (@(posedge clk) disable iff (!por_n)
    reset_req |-> pullup_en);

  a_r4_dir_write: assert property (@(posedge clk) disable iff (!por_n)
    (soft_rst_n && bus_we && bus_addr == A_DIR)
      |=> ({{(DATA_W-NPINS){1'b0}}, dir_w} == ($past(bus_wdata) & LOW_MASK)));
endmodule

// File: tb/gpio_mixport_test.sv
`timescale 1ns/1ps
module gpio_mixport_test;
  localparam int NP = 4, DW = 8, AW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          por_n = 1'b0, soft_rst_n = 1'b1, bus_we = 1'b0, mclr_cfg = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [NP-1:0] pad_in = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] pad_oe, pad_out;
  logic [NP-2:0] ana_sel;
  logic          pullup_en, reset_req;

  gpio_mixport uut (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .ana_sel(ana_sel), .mclr_cfg(mclr_cfg),
    .pullup_en(pullup_en), .reset_req(reset_req)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  // behavioural model state
  int m_dir = 15, m_ana = 7, m_lat = 0, m_known = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic int exp_read(int a);
    int r;
    r = 0;
    case (a)
      0: begin
        for (int i = 0; i < NP - 1; i++)
          if (((m_ana >> i) & 1) == 0 && pad_in[i]) r += (1 << i);
        if (!mclr_cfg && pad_in[NP-1]) r += (1 << (NP - 1));
      end
      1: r = m_dir;
      2: r = m_ana;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic compare_all();
    int oe;
    oe = 0;
    for (int i = 0; i < NP - 1; i++)
      if (((m_dir >> i) & 1) == 0 && ((m_ana >> i) & 1) == 0) oe += (1 << i);
    chk("R5", 32'(pad_oe[NP-2:0]), oe, "pad_oe");
    chk("R6", {pad_oe[NP-1], pad_out[NP-1]}, 0, "top pin drive");
    chk("R5", 32'(pad_out[NP-2:0]) & m_known, m_lat & m_known, "pad_out");
    chk("R10", 32'(ana_sel), m_ana, "ana_sel");
    chk("R8", pullup_en, mclr_cfg, "pullup_en");
    chk("R8", reset_req, (mclr_cfg && !pad_in[NP-1]) ? 1 : 0, "reset_req");
    chk(bus_addr == 0 ? "R7" : "R4", bus_rdata, exp_read(int'(bus_addr)), "bus_rdata");
  endtask

  // one clock: model updates at the rising edge, compare at the falling edge
  task automatic step();
    @(posedge clk);
    if (!por_n) begin
      m_dir = 15; m_ana = 7; m_known = 0;
    end else if (!soft_rst_n) begin
      m_dir = 15; m_ana = 7;
    end else if (bus_we) begin
      case (int'(bus_addr))
        0: begin m_lat = int'(bus_wdata) & 7; m_known = 7; end
        1: m_dir = int'(bus_wdata) & 15;
        2: m_ana = int'(bus_wdata) & 7;
        default: ;
      endcase
    end
    @(negedge clk);
    if (por_n) compare_all();
  endtask

  task automatic wr(int a, int d);
    bus_addr = AW'(a); bus_wdata = DW'(d); bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rdchk(int a, string tag);
    bus_addr = AW'(a);
    #2;
    chk(tag, bus_rdata, exp_read(a), "register read");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    por_n = 1'b0;
    step(); step();
    #3;
    // R1: state held by power-on reset
    chk("R1", 32'(pad_oe), 0, "pad_oe in reset");
    chk("R1", 32'(ana_sel), 7, "ana_sel in reset");
    por_n = 1'b1;
    step();
    rdchk(1, "R1");
    rdchk(2, "R1");
    rdchk(3, "R4");

    // R4 / R5: basic writes and the output path
    wr(0, 'h05);
    wr(1, 'h00);
    rdchk(1, "R4");
    chk("R5", 32'(pad_oe), 0, "analog pins stay undriven");
    wr(2, 'h00);
    rdchk(2, "R4");
    chk("R5", 32'(pad_oe), 7, "digital outputs driven");
    chk("R5", 32'(pad_out), 5, "latch on pads");
    chk("R6", pad_oe[NP-1], 0, "top pin not driven with dir bit 0");
    rdchk(1, "R6");

    // R9: upper write bits dropped
    wr(1, 'hF0);
    rdchk(1, "R9");
    wr(0, 'hFA);
    wr(1, 'h00);
    chk("R9", 32'(pad_out), 2, "data bit 3 not stored");

    // sweep every direction and analog combination
    for (int d = 0; d < 8; d++) begin
      for (int an = 0; an < 8; an++) begin
        wr(1, d);
        wr(2, an);
        bus_addr = '0;
        step();
      end
    end

    // R7 / R8: all pad levels, analog masks and reset-enable settings
    for (int cfg = 0; cfg < 2; cfg++) begin
      mclr_cfg = cfg[0];
      for (int an = 0; an < 8; an += 3) begin
        wr(2, an);
        for (int p = 0; p < 16; p++) begin
          pad_in = NP'(p);
          rdchk(0, cfg == 1 ? "R8" : "R7");
          step();
        end
      end
    end
    mclr_cfg = 1'b0;

    // R2 / R3: soft reset restores controls, keeps latch
    wr(0, 'h02);
    wr(1, 'h00);
    wr(2, 'h00);
    soft_rst_n = 1'b0;
    bus_addr = AW'(1); bus_wdata = '0; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
    soft_rst_n = 1'b1;
    rdchk(1, "R2");
    rdchk(2, "R2");
    wr(1, 'h00);
    wr(2, 'h00);
    chk("R3", 32'(pad_out[NP-2:0]), 2, "latch kept over soft reset");

    // power-on reset again, asynchronous
    por_n = 1'b0;
    #3;
    chk("R1", 32'(pad_oe), 0, "async power-on clears drive");
    step();
    por_n = 1'b1;
    step();
    rdchk(1, "R1");

    done = 1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end
endmodule